// File: doc/BRIEF.md
# Oversampled NRZ Bit Sampler with Edge Resynchronisation

This block recovers NRZ bits from a single-wire bus whose transmitter is not clocked with the receiver. It runs on a sample clock at SPB times the nominal bit rate and takes one line sample per clock. The raw line first goes through a multi-flop synchronizer. In idle the block waits for a dominant (low) period that is followed by a return to recessive (high). The low period is a transmission start pattern. Its rising edge sets the first bit-phase anchor and is reported as a one-cycle start pulse, together with the number of low samples that came before it.

While receiving, the block takes one sample per bit at a fixed offset after the current anchor. By default that offset is mid-bit. Every recessive-to-dominant edge on the line moves the anchor to that edge. The running bit index continues without a break, so a transmitter that runs a few percent fast or slow stays inside the sampling window as long as falling edges come often enough. The block has no frame parser. A synchronous abort input returns it to idle and clears its bit phase, and a new start pattern is then needed.

Top module: `bit_sampler`

## Requirements
- R1: The line input passes through SYNC_STAGES (default 2) synchronizer flops, and the synchronizer resets to high. A value presented to `rx_i` at clock edge k reaches the registered outputs at edge k+2. An output that depends only on that value is visible after edge k+2.
- R2: In idle, a low synchronized sample starts a start-pattern low period. The first high sample after it ends the period. That high sample raises `sot_o` for exactly one cycle.
- R3: At the start pulse, `sot_len_o` takes the number of low samples in the period. This count is at least 1 and saturates at 2^LEN_W-1. It holds its value until the next start pulse.
- R4: While receiving, `bit_vld_o` is a one-cycle strobe. The first strobe carries the line sample taken SP = SPB*SAMPLE_PCT/100 samples after the rising edge of the start pattern. Without further edges, each later strobe comes SPB samples after the previous one.
- R5: While receiving, a high-to-low step of the synchronized line moves the anchor to that sample. The next strobe then carries the sample SP samples after the edge. If the edge lands exactly on a pending sample point, that sample is dropped in favour of the new anchor. `bit_o` is the synchronized line value at the sample point.
- R6: `bit_idx_o` is 0 on the first strobe after a start pulse and rises by one on each strobe, re-anchors included. It saturates at 2^IDX_W-1.
- R7: The recovered bit sequence equals the transmitted one when every fourth bit is one sample longer or one sample shorter than SPB, and a falling edge occurs at least once every 10 bits.
- R8: An asserted `abort_i` forces the block to idle on the next edge. From that edge on there is no strobe and no start pulse until a complete new low-then-high start pattern arrives.
- R9: After reset, `bit_vld_o`, `sot_o`, `bit_o`, `sot_len_o` and `bit_idx_o` are all 0.
- R10: No strobe appears in idle, during the start-pattern low period, or in the cycle right after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, SPB times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Synchronous return to idle |
| rx_i | input | 1 | Asynchronous bus line, low is dominant |
| sot_o | output | 1 | One-cycle pulse at the end of the start-pattern low period |
| sot_len_o | output | LEN_W | Low-period length in samples, saturating |
| bit_o | output | 1 | Recovered bit value |
| bit_vld_o | output | 1 | Strobe that marks a new `bit_o` |
| bit_idx_o | output | IDX_W | Index of the recovered bit since the start pulse, saturating |

## Verification
A wrong bit phase moves `bit_vld_o` away from its expected cycle. It shows within one bit period, that is, no later than SPB samples after the last anchor. A phase that is off by more than half a bit also makes `bit_o` disagree with the transmitted bit on the next transition. A stuck acquisition state appears as a missing or repeated `sot_o`, or as strobes on an idle line. A broken index counter is caught at the very next strobe. The bench compares every cycle of every frame against arithmetic expectations, so each of these faults surfaces within a few samples of where it first occurs.

// File: rtl/bsamp_pkg.sv
package bsamp_pkg;

   typedef enum logic [1:0] {
      ACQ_IDLE = 2'd0,
      ACQ_LOW  = 2'd1,
      ACQ_RECV = 2'd2
   } acq_state_e;

endpackage

// File: rtl/bsamp_sync.sv
module bsamp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic rx_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // R1: shift chain, reset to recessive so that no false start follows reset
   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= rx_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rx_o   = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/bsamp_acq.sv
module bsamp_acq
   import bsamp_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             rx_s_i,
   output logic             recv_o,
   output logic             start_o,
   output logic             sot_o,
   output logic [LEN_W-1:0] sot_len_o
);

   localparam logic [LEN_W-1:0] LEN_MAX = '1;
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   acq_state_e       state_q;
   logic [LEN_W-1:0] low_cnt_q;

   // R2: the start pattern ends on the first high sample after the low period
   assign start_o = (state_q == ACQ_LOW) && rx_s_i && !abort_i;
   assign recv_o  = (state_q == ACQ_RECV) && !abort_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ACQ_IDLE;
         low_cnt_q <= '0;
         sot_o     <= 1'b0;
         sot_len_o <= '0;
      end else if (abort_i) begin
         // R8
         state_q   <= ACQ_IDLE;
         low_cnt_q <= '0;
         sot_o     <= 1'b0;
      end else begin
         sot_o <= 1'b0;
         unique case (state_q)
            ACQ_IDLE: begin
               if (!rx_s_i) begin
                  state_q   <= ACQ_LOW;
                  low_cnt_q <= LEN_ONE;
               end
            end
            ACQ_LOW: begin
               if (rx_s_i) begin
                  state_q   <= ACQ_RECV;
                  sot_o     <= 1'b1;
                  sot_len_o <= low_cnt_q;   // R3
               end else if (low_cnt_q != LEN_MAX) begin
                  low_cnt_q <= low_cnt_q + LEN_ONE;
               end
            end
            ACQ_RECV: begin
               state_q <= ACQ_RECV;
            end
            default: state_q <= ACQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bsamp_timer.sv
module bsamp_timer #(
   parameter int SPB   = 8,
   parameter int SP    = 4,
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             recv_i,
   input  logic             start_i,
   input  logic             fall_i,
   input  logic             rx_s_i,
   output logic             bit_o,
   output logic             bit_vld_o,
   output logic [IDX_W-1:0] bit_idx_o
);

   localparam int               CW      = $clog2(SPB);
   localparam logic [CW-1:0]    PH_ONE  = CW'(1);
   localparam logic [CW-1:0]    PH_SP   = CW'(SP);
   localparam logic [CW-1:0]    PH_LAST = CW'(SPB - 1);
   localparam logic [IDX_W-1:0] IDX_MAX = '1;
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
   localparam bit               POW2    = ((SPB & (SPB - 1)) == 0);

   logic [CW-1:0]    ph_q;
   logic [CW-1:0]    ph_inc;
   logic [IDX_W-1:0] idx_cnt_q;
   logic             hit;

   // phase wrap: free binary wrap when SPB is a power of two, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign ph_inc = ph_q + PH_ONE;
      end else begin : g_wrap_cmp
         assign ph_inc = (ph_q == PH_LAST) ? '0 : ph_q + PH_ONE;
      end
   endgenerate

   // R4 R5: sample point SP samples past the anchor; a re-anchoring edge wins
   assign hit = recv_i && !fall_i && (ph_q == PH_SP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= '0;
         idx_cnt_q <= '0;
         bit_o     <= 1'b0;
         bit_vld_o <= 1'b0;
         bit_idx_o <= '0;
      end else if (abort_i) begin
         // R8: phase cleared, no strobe
         ph_q      <= '0;
         idx_cnt_q <= '0;
         bit_vld_o <= 1'b0;
      end else begin
         bit_vld_o <= 1'b0;
         if (start_i) begin
            ph_q      <= PH_ONE;
            idx_cnt_q <= '0;
         end else if (recv_i && fall_i) begin
            ph_q <= PH_ONE;
         end else if (recv_i) begin
            ph_q <= ph_inc;
         end
         if (hit) begin
            bit_o     <= rx_s_i;
            bit_vld_o <= 1'b1;
            bit_idx_o <= idx_cnt_q;           // R6
            if (idx_cnt_q != IDX_MAX) idx_cnt_q <= idx_cnt_q + IDX_ONE;
         end
      end
   end

endmodule

// File: rtl/bit_sampler.sv
module bit_sampler #(
   parameter int SPB         = 8,
   parameter int SAMPLE_PCT  = 50,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = 8,
   parameter int IDX_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             rx_i,
   output logic             sot_o,
   output logic [LEN_W-1:0] sot_len_o,
   output logic             bit_o,
   output logic             bit_vld_o,
   output logic [IDX_W-1:0] bit_idx_o
);

   localparam int SP = (SPB * SAMPLE_PCT) / 100;

   generate
      if (SPB < 4) begin : g_bad_spb
         $error("bit_sampler: SPB must be 4 or more");
      end
      if (SP < 1 || SP > SPB - 1) begin : g_bad_sp
         $error("bit_sampler: sample point must fall inside the bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bit_sampler: at least two synchronizer stages needed");
      end
      if (LEN_W < 2 || IDX_W < 2) begin : g_bad_w
         $error("bit_sampler: counter widths must be 2 or more");
      end
   endgenerate

   logic rx_s;
   logic fall;
   logic recv;
   logic start;

   bsamp_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .rx_o   (rx_s),
      .fall_o (fall)
   );

   bsamp_acq #(
      .LEN_W (LEN_W)
   ) u_acq (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (abort_i),
      .rx_s_i    (rx_s),
      .recv_o    (recv),
      .start_o   (start),
      .sot_o     (sot_o),
      .sot_len_o (sot_len_o)
   );

   bsamp_timer #(
      .SPB   (SPB),
      .SP    (SP),
      .IDX_W (IDX_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (abort_i),
      .recv_i    (recv),
      .start_i   (start),
      .fall_i    (fall),
      .rx_s_i    (rx_s),
      .bit_o     (bit_o),
      .bit_vld_o (bit_vld_o),
      .bit_idx_o (bit_idx_o)
   );

endmodule

// File: rtl/bit_sampler_chk.sv
module bit_sampler_chk #(
   parameter int LEN_W = 8,
   parameter int IDX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             abort_i,
   input logic             sot_o,
   input logic [LEN_W-1:0] sot_len_o,
   input logic             bit_vld_o,
   input logic [IDX_W-1:0] bit_idx_o
);

   localparam logic [IDX_W-1:0] IMAX = '1;

   logic [IDX_W-1:0] strobes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              strobes_q <= '0;
      else if (abort_i || sot_o)               strobes_q <= '0;
      else if (bit_vld_o && strobes_q != IMAX) strobes_q <= strobes_q + IDX_W'(1);
   end

   // R8
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!bit_vld_o && !sot_o));

   // R2
   sot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sot_o |=> !sot_o);

   // R10
   sot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sot_o |-> (!bit_vld_o ##1 !bit_vld_o));

   // R4
   vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |=> !bit_vld_o);

   // R3
   sot_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sot_o |-> (sot_len_o != '0));

   // R3
   sot_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sot_o |-> $stable(sot_len_o));

   // R6
   idx_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |-> (bit_idx_o == strobes_q));

endmodule

bind bit_sampler bit_sampler_chk #(
   .LEN_W (LEN_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .abort_i   (abort_i),
   .sot_o     (sot_o),
   .sot_len_o (sot_len_o),
   .bit_vld_o (bit_vld_o),
   .bit_idx_o (bit_idx_o)
);

// File: tb/tb_bit_sampler.sv
module tb_bit_sampler;

   localparam int CLK_PERIOD = 10;
   localparam int SPB   = 8;
   localparam int SP    = 4;
   localparam int LEN_W = 6;
   localparam int IDX_W = 6;
   localparam int LMAX  = (1 << LEN_W) - 1;
   localparam int IMAX  = (1 << IDX_W) - 1;
   localparam int MAXS  = 1200;
   localparam int MAXB  = 128;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             abort_i;
   logic             rx_i;
   logic             sot_o;
   logic [LEN_W-1:0] sot_len_o;
   logic             bit_o;
   logic             bit_vld_o;
   logic [IDX_W-1:0] bit_idx_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic wave     [MAXS];
   logic intended [MAXB];
   bit   exp_vld  [MAXS];
   bit   exp_sot  [MAXS];
   logic exp_bit  [MAXS];
   int   exp_idx  [MAXS];
   int   exp_ord  [MAXS];
   int   nsamp, nbits, exp_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   bit_sampler #(
      .SPB   (SPB),
      .LEN_W (LEN_W),
      .IDX_W (IDX_W)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (abort_i),
      .rx_i      (rx_i),
      .sot_o     (sot_o),
      .sot_len_o (sot_len_o),
      .bit_o     (bit_o),
      .bit_vld_o (bit_vld_o),
      .bit_idx_o (bit_idx_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic int width_of(input int i, input int mode);
      if (mode == 1 && (i % 4) == 3) return SPB + 1;
      if (mode == 2 && (i % 4) == 3) return SPB - 1;
      return SPB;
   endfunction

   task automatic add_bit(input logic v, input int mode);
      int w;
      w = width_of(nbits, mode);
      for (int j = 0; j < w; j++) begin
         wave[nsamp] = v;
         nsamp++;
      end
      intended[nbits] = v;
      nbits++;
   endtask

   // idle, low start pattern, leading 1, then bytes each led by a 1,0 pair
   task automatic build(input int pre, input int low_len, input int nbytes,
                        input int mode, input logic [7:0] seed);
      logic [7:0] d;
      nsamp = 0;
      nbits = 0;
      for (int j = 0; j < pre; j++) begin wave[nsamp] = 1'b1; nsamp++; end
      for (int j = 0; j < low_len; j++) begin wave[nsamp] = 1'b0; nsamp++; end
      add_bit(1'b1, mode);
      for (int b = 0; b < nbytes; b++) begin
         d = seed ^ 8'(b * 8'h3B);
         add_bit(1'b1, mode);
         add_bit(1'b0, mode);
         for (int k = 7; k >= 0; k--) add_bit(d[k], mode);
      end
      for (int j = 0; j < 24; j++) begin wave[nsamp] = 1'b1; nsamp++; end
   endtask

   task automatic compute;
      int lo, hi, anchor, cnt;
      for (int s = 0; s < MAXS; s++) begin
         exp_vld[s] = 1'b0; exp_sot[s] = 1'b0; exp_bit[s] = 1'b0;
         exp_idx[s] = 0;    exp_ord[s] = 0;
      end
      lo = 0;
      while (wave[lo]) lo++;
      hi = lo;
      while (!wave[hi]) hi++;
      exp_sot[hi] = 1'b1;
      exp_len = (hi - lo > LMAX) ? LMAX : hi - lo;
      anchor = hi;
      cnt = 0;
      for (int s = hi + 1; s < nsamp; s++) begin
         if (wave[s-1] && !wave[s]) begin
            anchor = s;
         end else if (((s - anchor) % SPB) == SP) begin
            exp_vld[s] = 1'b1;
            exp_bit[s] = wave[s];
            exp_idx[s] = (cnt > IMAX) ? IMAX : cnt;
            exp_ord[s] = cnt;
            cnt++;
         end
      end
   endtask

   task automatic check_at(input int d);
      logic want;
      chk(bit_vld_o == exp_vld[d], "R4 R5 R10 strobe timing", int'(bit_vld_o), int'(exp_vld[d]));
      if (exp_vld[d] && bit_vld_o) begin
         chk(bit_o == exp_bit[d], "R5 sampled value", int'(bit_o), int'(exp_bit[d]));
         chk(int'(bit_idx_o) == exp_idx[d], "R6 bit index", int'(bit_idx_o), exp_idx[d]);
         want = (exp_ord[d] < nbits) ? intended[exp_ord[d]] : 1'b1;
         chk(bit_o == want, "R7 recovered sequence", int'(bit_o), int'(want));
      end
      chk(sot_o == exp_sot[d], "R1 R2 start pulse", int'(sot_o), int'(exp_sot[d]));
      if (exp_sot[d])
         chk(int'(sot_len_o) == exp_len, "R3 low length", int'(sot_len_o), exp_len);
   endtask

   // outputs seen at iteration c come from the drive of iteration c-3
   task automatic run(input int limit);
      for (int c = 0; c < limit + 3; c++) begin
         @(negedge clk);
         if (c >= 3) check_at(c - 3);
         rx_i = (c < nsamp) ? wave[c] : 1'b1;
      end
   endtask

   task automatic abort_seq;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         abort_i = 1'b1;
         rx_i    = 1'b1;
      end
      @(negedge clk);
      abort_i = 1'b0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         chk(!bit_vld_o, "R8 no strobe after abort", int'(bit_vld_o), 0);
         chk(!sot_o, "R8 no start after abort", int'(sot_o), 0);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      rst_n   = 1'b0;
      abort_i = 1'b0;
      rx_i    = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      chk(!bit_vld_o, "R9 reset strobe", int'(bit_vld_o), 0);
      chk(!sot_o, "R9 reset start", int'(sot_o), 0);
      chk(!bit_o, "R9 reset bit", int'(bit_o), 0);
      chk(sot_len_o == '0, "R9 reset length", int'(sot_len_o), 0);
      chk(bit_idx_o == '0, "R9 reset index", int'(bit_idx_o), 0);

      // sweep of start-pattern low lengths at nominal rate
      for (int n = 1; n <= 12; n++) begin
         build(10, n, 1, 0, 8'(8'hA5 + n));
         compute();
         run(nsamp);
         abort_seq();
      end
      // R7: slow and fast transmitters
      build(6, 5, 3, 1, 8'h3C); compute(); run(nsamp); abort_seq();
      build(6, 4, 3, 2, 8'hC3); compute(); run(nsamp); abort_seq();
      build(6, 2, 2, 1, 8'h00); compute(); run(nsamp); abort_seq();
      // R3 and R6 saturation: long low period, more bits than the index holds
      build(8, 70, 7, 0, 8'h96); compute(); run(nsamp); abort_seq();
      // R8: abort in the middle of a frame, then a clean frame
      build(8, 3, 2, 0, 8'h5A); compute(); run(nsamp / 2); abort_seq();
      build(8, 3, 2, 2, 8'h81); compute(); run(nsamp); abort_seq();

      done = 1'b1;
      finish_run();
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         finish_run();
      end
   end

endmodule